// File: doc/BRIEF.md
# Auto-Incrementing Packet Data Window

This block lets a microcontroller reach the bytes of one buffered packet through a single data port, without ever presenting a full buffer address. Software stages the low byte of an 11-bit byte offset, then writes a control byte. That control byte carries the upper offset bits, a packet-source select, an auto-advance enable and a transfer direction. The packet is named either by a local packet-number register or by the head entry of an external receive packet-number queue.

In write mode, each window write stores one byte at the current offset of the selected packet. Entering read mode flushes a four-entry prefetch FIFO and starts refilling it from the single-port buffer RAM at once, so a read returns the head byte with no wait state. With auto-advance on, every accepted window access moves the offset forward by one, and the prefetcher runs ahead along the packet. An access past the last legal offset is refused, sets a sticky overflow flag and leaves the offset where it is. A switch from write to read that comes too soon after the last window write raises a sticky protocol-error flag.

Top module: `pdw_window`

## Requirements
- R1: After reset the offset is 0, the block is in write mode, `win_rdy` is low, and `ovf` and `proto_err` are low.
- R2: Writing `reg_addr`=0 only stages a low byte. Writing `reg_addr`=1 commits the offset as {`reg_wdata`[2:0], staged low byte}. The same write loads control bits 7 (source select: 1 = receive queue head), 6 (auto-advance) and 5 (direction: 1 = read). `reg_addr`=2 loads the packet-number register.
- R3: In write mode, a `win_wr` stores `win_wdata` at the current offset of the selected packet. A `win_rd` in write mode has no effect on the offset.
- R4: With auto-advance set, each accepted window access raises the offset by exactly one. With it clear, the offset holds.
- R5: After a commit in read mode, `win_rdy` rises within 3 clock cycles and `win_rdata` is the byte at the current offset. With auto-advance clear, reads do not consume the byte and the offset does not change.
- R6: With auto-advance set in read mode, successive reads return consecutive bytes of the packet. The prefetch FIFO never holds more than 4 bytes.
- R7: Control bit 7 = 0 maps the window to the packet-number register. Control bit 7 = 1 maps it to `rxq_head`.
- R8: A window access at an offset above 1277 stores nothing, leaves the offset unchanged and sets `ovf`. `ovf` stays set until the next commit. Prefetch never fetches past offset 1277.
- R9: A commit that changes direction from write to read sets `proto_err` (sticky until reset) if fewer than 60 cycles have passed since the last write-mode `win_wr`. If 60 or more cycles have passed, `proto_err` stays low.
- R10: A `win_wr` in read mode changes neither the buffer RAM nor the offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 low offset, 1 control/high offset, 2 packet number |
| reg_wdata | input | 8 | Register write data |
| rxq_head | input | PNUM_W | Packet number at the head of the receive queue |
| win_wr | input | 1 | Data window write strobe |
| win_wdata | input | DW | Data window write byte |
| win_rd | input | 1 | Data window read strobe |
| win_rdata | output | DW | Byte at the current offset (valid while win_rdy) |
| win_rdy | output | 1 | Read data available |
| win_ptr | output | OFF_W | Current window offset |
| read_mode | output | 1 | Direction currently in force (1 = read) |
| ovf | output | 1 | Sticky out-of-range access flag |
| proto_err | output | 1 | Sticky early direction-switch flag |

## Verification
A corrupt offset shows on `win_ptr` at the next sampling point after the access that caused it. A wrong packet select or a wrong offset in the fetch path shows as a wrong `win_rdata` byte, at the latest three cycles after the commit that entered read mode. A fetch pointer that drifts away from the offset shows as out-of-order bytes within the first few reads of an auto-advance burst. A settle counter that is off by a margin shows only at the one commit that switches direction, through `proto_err`. The bench therefore brackets that threshold with switches well inside and well outside it.

// File: rtl/pdw_pkg.sv
package pdw_pkg;

  // register select codes on reg_addr
  typedef enum logic [1:0] {
    RA_OFF_LO  = 2'd0,
    RA_CTRL_HI = 2'd1,
    RA_PKT     = 2'd2
  } reg_addr_e;

  // bit positions inside the control/high byte
  localparam int CB_SRC  = 7;
  localparam int CB_AUTO = 6;
  localparam int CB_DIR  = 5;

  typedef struct packed {
    logic src_rxq;
    logic auto_inc;
    logic dir_read;
  } win_ctrl_t;

  function automatic logic in_window(int unsigned off, int unsigned max_off);
    return off <= max_off;
  endfunction

  function automatic int unsigned buf_index(int unsigned pkt, int unsigned off,
                                            int unsigned stride, int unsigned max_off);
    if (off > max_off) return 0;
    return pkt * stride + off;
  endfunction

  function automatic logic fifo_room(int unsigned held, int unsigned inflight,
                                     int unsigned depth);
    return (held + inflight) < depth;
  endfunction

endpackage

// File: rtl/pdw_regs.sv
module pdw_regs
  import pdw_pkg::*;
#(
  parameter int OFF_W  = 11,
  parameter int PNUM_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic              commit,
  output logic [OFF_W-1:0]  new_ptr,
  output win_ctrl_t         new_ctrl,
  output win_ctrl_t         ctrl_q,
  output logic [PNUM_W-1:0] pkt_q
);
  localparam int HI_W = OFF_W - 8;

  logic [7:0] lo_stage_q;

  assign commit   = reg_wr && (reg_addr == RA_CTRL_HI);
  assign new_ptr  = {reg_wdata[HI_W-1:0], lo_stage_q};
  assign new_ctrl = '{src_rxq:  reg_wdata[CB_SRC],
                      auto_inc: reg_wdata[CB_AUTO],
                      dir_read: reg_wdata[CB_DIR]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_stage_q <= '0;
      ctrl_q     <= '0;
      pkt_q      <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        RA_OFF_LO:  lo_stage_q <= reg_wdata;
        RA_CTRL_HI: ctrl_q     <= new_ctrl;
        RA_PKT:     pkt_q      <= reg_wdata[PNUM_W-1:0];
        default:    ;
      endcase
    end
  end

endmodule

// File: rtl/pdw_settle.sv
module pdw_settle #(
  parameter int SETTLE_CYC = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_evt,
  input  logic switch_evt,
  output logic proto_err
);
  localparam int CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(SETTLE_CYC);

  logic [CNT_W-1:0] since_wr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_wr_q <= LIMIT;
      proto_err  <= 1'b0;
    end else begin
      if (wr_evt)
        since_wr_q <= CNT_W'(1);
      else if (since_wr_q < LIMIT)
        since_wr_q <= since_wr_q + 1'b1;
      if (switch_evt && (since_wr_q < LIMIT))
        proto_err <= 1'b1;
    end
  end

endmodule

// File: rtl/pdw_ram.sv
module pdw_ram #(
  parameter int WORDS = 2560,
  parameter int DW    = 8,
  parameter int AW    = 12
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end

endmodule

// File: rtl/pdw_prefetch.sv
module pdw_prefetch #(
  parameter int DEPTH = 4,
  parameter int DW    = 8,
  parameter int CW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] slot [DEPTH];
  logic [IW-1:0] wr_idx_q, rd_idx_q;
  logic          do_push, do_pop;

  function automatic logic [IW-1:0] step(logic [IW-1:0] idx);
    return (int'(idx) == DEPTH - 1) ? '0 : idx + 1'b1;
  endfunction

  assign do_push = push && (int'(count) < DEPTH);
  assign do_pop  = pop && (count != '0);
  assign head    = slot[rd_idx_q];

  always_ff @(posedge clk) begin
    if (do_push && !flush) slot[wr_idx_q] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_idx_q <= '0;
      rd_idx_q <= '0;
      count    <= '0;
    end else begin
      if (do_push) wr_idx_q <= step(wr_idx_q);
      if (do_pop)  rd_idx_q <= step(rd_idx_q);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

endmodule

// File: rtl/pdw_window.sv
module pdw_window
  import pdw_pkg::*;
#(
  parameter int DW         = 8,
  parameter int OFF_W      = 11,
  parameter int MAX_OFF    = 1277,
  parameter int PKT_STRIDE = 1280,
  parameter int PNUM_W     = 1,
  parameter int FIFO_DEPTH = 4,
  parameter int SETTLE_CYC = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  input  logic [PNUM_W-1:0] rxq_head,
  input  logic              win_wr,
  input  logic [DW-1:0]     win_wdata,
  input  logic              win_rd,
  output logic [DW-1:0]     win_rdata,
  output logic              win_rdy,
  output logic [OFF_W-1:0]  win_ptr,
  output logic              read_mode,
  output logic              ovf,
  output logic              proto_err
);
  localparam int NUM_PKT   = 1 << PNUM_W;
  localparam int RAM_WORDS = NUM_PKT * PKT_STRIDE;
  localparam int AW        = $clog2(RAM_WORDS);
  localparam int CW        = $clog2(FIFO_DEPTH + 1);

  // register file
  logic              commit;
  logic [OFF_W-1:0]  new_ptr;
  win_ctrl_t         new_ctrl, ctrl_q;
  logic [PNUM_W-1:0] pkt_q;

  pdw_regs #(.OFF_W(OFF_W), .PNUM_W(PNUM_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .commit(commit), .new_ptr(new_ptr),
    .new_ctrl(new_ctrl), .ctrl_q(ctrl_q), .pkt_q(pkt_q)
  );

  logic auto_inc;
  logic [PNUM_W-1:0] sel_pkt;
  assign read_mode = ctrl_q.dir_read;
  assign auto_inc  = ctrl_q.auto_inc;
  assign sel_pkt   = ctrl_q.src_rxq ? rxq_head : pkt_q;

  // window access events, brought out for the checker
  logic [OFF_W-1:0] fetch_ptr_q;
  logic             rd_vld_q;
  logic [CW-1:0]    fifo_cnt;
  logic             ptr_ok, fetch_ok;
  logic             wr_evt, rd_evt, wr_accept, rd_accept, ovf_evt;
  logic             advance, issue, ram_we;

  assign ptr_ok    = in_window(int'(win_ptr), MAX_OFF);
  assign fetch_ok  = in_window(int'(fetch_ptr_q), MAX_OFF);
  assign wr_evt    = win_wr && !read_mode && !commit;
  assign rd_evt    = win_rd && read_mode && !commit;
  assign wr_accept = wr_evt && ptr_ok;
  assign rd_accept = rd_evt && ptr_ok && (fifo_cnt != '0);
  assign ovf_evt   = (wr_evt || rd_evt) && !ptr_ok;
  assign advance   = (wr_accept || rd_accept) && auto_inc;
  assign ram_we    = wr_accept;
  assign issue     = read_mode && !commit && fetch_ok
                   && fifo_room(int'(fifo_cnt), int'(rd_vld_q), FIFO_DEPTH)
                   && (auto_inc || (fifo_cnt == '0 && !rd_vld_q));
  assign win_rdy   = read_mode && (fifo_cnt != '0);

  // offset pointer and overflow flag
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_ptr <= '0;
      ovf     <= 1'b0;
    end else if (commit) begin
      win_ptr <= new_ptr;
      ovf     <= 1'b0;
    end else begin
      if (advance) win_ptr <= win_ptr + 1'b1;
      if (ovf_evt) ovf <= 1'b1;
    end
  end

  // prefetch address generator
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_ptr_q <= '0;
      rd_vld_q    <= 1'b0;
    end else begin
      rd_vld_q <= issue;
      if (commit)
        fetch_ptr_q <= new_ptr;
      else if (issue && auto_inc)
        fetch_ptr_q <= fetch_ptr_q + 1'b1;
    end
  end

  // buffer RAM
  logic [OFF_W-1:0] ram_off;
  logic [AW-1:0]    ram_addr;
  logic [DW-1:0]    ram_rdata;

  assign ram_off  = issue ? fetch_ptr_q : win_ptr;
  assign ram_addr = AW'(buf_index(int'(sel_pkt), int'(ram_off), PKT_STRIDE, MAX_OFF));

  pdw_ram #(.WORDS(RAM_WORDS), .DW(DW), .AW(AW)) u_ram (
    .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(win_wdata), .rdata(ram_rdata)
  );

  pdw_prefetch #(.DEPTH(FIFO_DEPTH), .DW(DW), .CW(CW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(commit), .push(rd_vld_q && !commit),
    .push_data(ram_rdata), .pop(rd_accept && auto_inc),
    .head(win_rdata), .count(fifo_cnt)
  );

  // direction settle check
  logic switch_evt;
  assign switch_evt = commit && new_ctrl.dir_read && !ctrl_q.dir_read;

  pdw_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .switch_evt(switch_evt),
    .proto_err(proto_err)
  );

endmodule

// File: rtl/pdw_window_chk.sv
module pdw_window_chk #(
  parameter int OFF_W      = 11,
  parameter int FIFO_DEPTH = 4,
  parameter int CW         = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             commit,
  input logic [OFF_W-1:0] new_ptr,
  input logic [OFF_W-1:0] win_ptr,
  input logic             auto_inc,
  input logic             read_mode,
  input logic             win_rdy,
  input logic             wr_accept,
  input logic             rd_accept,
  input logic             ovf_evt,
  input logic             ovf,
  input logic             proto_err,
  input logic             ram_we,
  input logic [CW-1:0]    fifo_cnt
);

  // R2: a commit loads the offset
  p_commit_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> win_ptr == $past(new_ptr));

  // R4: auto-advance steps by one per accepted access
  p_step_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_accept || rd_accept) && auto_inc) |=> win_ptr == OFF_W'($past(win_ptr) + 1'b1));

  // R4: without auto-advance the offset holds
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_inc && !commit) |=> $stable(win_ptr));

  // R5: read data is only offered in read mode
  p_rdy_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    win_rdy |-> read_mode);

  // R6: prefetch never exceeds its depth
  p_fifo_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fifo_cnt) <= FIFO_DEPTH);

  // R8: a refused access holds the offset and raises the flag
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> $stable(win_ptr) && ovf);

  // R8: overflow stays until a commit
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !commit) |=> ovf);

  // R9: protocol error is sticky
  p_proto_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

  // R10: no RAM write in read mode
  p_ro_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
    read_mode |-> !ram_we);

endmodule

bind pdw_window pdw_window_chk #(
  .OFF_W(OFF_W), .FIFO_DEPTH(FIFO_DEPTH), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .commit(commit), .new_ptr(new_ptr),
  .win_ptr(win_ptr), .auto_inc(auto_inc), .read_mode(read_mode),
  .win_rdy(win_rdy), .wr_accept(wr_accept), .rd_accept(rd_accept),
  .ovf_evt(ovf_evt), .ovf(ovf), .proto_err(proto_err), .ram_we(ram_we),
  .fifo_cnt(fifo_cnt)
);

// File: tb/pdw_window_tb.sv
module pdw_window_tb;
  localparam int DW = 8, OFF_W = 11, PNUM_W = 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n = 1'b0;
  logic              reg_wr = 1'b0;
  logic [1:0]        reg_addr = '0;
  logic [7:0]        reg_wdata = '0;
  logic [PNUM_W-1:0] rxq_head = '0;
  logic              win_wr = 1'b0;
  logic [DW-1:0]     win_wdata = '0;
  logic              win_rd = 1'b0;
  logic [DW-1:0]     win_rdata;
  logic              win_rdy;
  logic [OFF_W-1:0]  win_ptr;
  logic              read_mode, ovf, proto_err;

  pdw_window u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .rxq_head(rxq_head), .win_wr(win_wr),
    .win_wdata(win_wdata), .win_rd(win_rd), .win_rdata(win_rdata),
    .win_rdy(win_rdy), .win_ptr(win_ptr), .read_mode(read_mode),
    .ovf(ovf), .proto_err(proto_err)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic reg_w(logic [1:0] a, logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic set_ptr(logic [10:0] p, logic src, logic aut, logic dir);
    reg_w(2'd0, p[7:0]);
    reg_w(2'd1, {src, aut, dir, 2'b00, p[10:8]});
  endtask

  task automatic win_w(logic [7:0] d);
    win_wr = 1'b1; win_wdata = d;
    @(negedge clk);
    win_wr = 1'b0;
  endtask

  task automatic wait_rdy(output int n);
    n = 0;
    while (!win_rdy && n < 6) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic win_r(output logic [7:0] d, output logic ok);
    int n;
    wait_rdy(n);
    ok = win_rdy;
    d  = win_rdata;
    if (ok) begin
      win_rd = 1'b1;
      @(negedge clk);
      win_rd = 1'b0;
    end
  endtask

  // {packet, offset, byte}
  localparam logic [19:0] VEC [8] = '{
    {1'b0, 11'd0,    8'h11}, {1'b0, 11'd1,    8'h22},
    {1'b0, 11'd640,  8'h33}, {1'b0, 11'd1277, 8'h44},
    {1'b1, 11'd0,    8'h55}, {1'b1, 11'd3,    8'h66},
    {1'b1, 11'd1000, 8'h77}, {1'b1, 11'd1276, 8'h88}
  };

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    logic ok;
    int n;

    do_reset();
    // R1 reset state
    check("R1 ptr", 32'(win_ptr), 0);
    check("R1 mode", 32'(read_mode), 0);
    check("R1 rdy", 32'(win_rdy), 0);
    check("R1 ovf", 32'(ovf), 0);
    check("R1 proto", 32'(proto_err), 0);

    // R2 low byte alone does not move the offset
    reg_w(2'd0, 8'h7A);
    check("R2 staged only", 32'(win_ptr), 0);

    // table: write phase
    for (int i = 0; i < 8; i++) begin
      reg_w(2'd2, {7'd0, VEC[i][19]});
      set_ptr(VEC[i][18:8], 1'b0, 1'b0, 1'b0);
      check("R2 commit", 32'(win_ptr), 32'(VEC[i][18:8]));
      win_w(VEC[i][7:0]);
      check("R4 hold on write", 32'(win_ptr), 32'(VEC[i][18:8]));
    end
    repeat (70) @(negedge clk);
    // table: read-back phase
    for (int i = 0; i < 8; i++) begin
      reg_w(2'd2, {7'd0, VEC[i][19]});
      set_ptr(VEC[i][18:8], 1'b0, 1'b0, 1'b1);
      win_r(d, ok);
      check("R5 rdy", 32'(ok), 1);
      check("R3 stored byte", 32'(d), 32'(VEC[i][7:0]));
      check("R5 not consumed", 32'(win_rdy), 1);
      check("R5 ptr held", 32'(win_ptr), 32'(VEC[i][18:8]));
    end
    check("R9 late switch ok", 32'(proto_err), 0);

    // R4/R3: auto-advance write burst, read strobe ignored in write mode
    reg_w(2'd2, 8'd0);
    set_ptr(11'd100, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 8; i++) win_w(8'hA0 + 8'(i));
    check("R4 advanced", 32'(win_ptr), 108);
    win_rd = 1'b1; @(negedge clk); win_rd = 1'b0;
    check("R3 read ignored", 32'(win_ptr), 108);
    repeat (70) @(negedge clk);
    // R6 consecutive prefetch reads
    set_ptr(11'd100, 1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 8; i++) begin
      win_r(d, ok);
      check("R6 rdy", 32'(ok), 1);
      check("R6 sequence", 32'(d), 32'(8'hA0 + 8'(i)));
    end
    check("R4 read advance", 32'(win_ptr), 108);

    // R7 source select
    rxq_head = 1'b1;
    reg_w(2'd2, 8'd0);
    set_ptr(11'd5, 1'b1, 1'b0, 1'b0);
    win_w(8'hC3);
    set_ptr(11'd5, 1'b0, 1'b0, 1'b0);
    win_w(8'h3C);
    repeat (70) @(negedge clk);
    set_ptr(11'd5, 1'b1, 1'b0, 1'b1);
    wait_rdy(n);
    check("R5 rdy latency", 32'(n <= 3), 1);
    check("R7 queue head pkt", 32'(win_rdata), 32'h C3);
    set_ptr(11'd5, 1'b0, 1'b0, 1'b1);
    win_r(d, ok);
    check("R7 register pkt", 32'(d), 32'h3C);

    // R10 writes ignored in read mode
    win_w(8'hEE);
    check("R10 ptr held", 32'(win_ptr), 5);
    set_ptr(11'd5, 1'b0, 1'b0, 1'b1);
    win_r(d, ok);
    check("R10 RAM unchanged", 32'(d), 32'h3C);

    // R8 overflow
    set_ptr(11'd1277, 1'b0, 1'b1, 1'b0);
    win_w(8'h99);
    check("R8 last offset", 32'(win_ptr), 1278);
    check("R8 no ovf yet", 32'(ovf), 0);
    win_w(8'h9A);
    check("R8 ovf set", 32'(ovf), 1);
    check("R8 no wrap", 32'(win_ptr), 1278);
    repeat (70) @(negedge clk);
    set_ptr(11'd1277, 1'b0, 1'b1, 1'b1);
    check("R8 ovf cleared", 32'(ovf), 0);
    win_r(d, ok);
    check("R8 last byte", 32'(d), 32'h99);
    wait_rdy(n);
    check("R8 no fetch beyond", 32'(win_rdy), 0);
    win_rd = 1'b1; @(negedge clk); win_rd = 1'b0;
    check("R8 read ovf", 32'(ovf), 1);
    check("R8 read hold", 32'(win_ptr), 1278);

    // R9 early switch
    do_reset();
    set_ptr(11'd0, 1'b0, 1'b0, 1'b0);
    win_w(8'h01);
    repeat (10) @(negedge clk);
    set_ptr(11'd0, 1'b0, 1'b0, 1'b1);
    check("R9 early switch", 32'(proto_err), 1);
    do_reset();
    win_w(8'h02);
    repeat (62) @(negedge clk);
    set_ptr(11'd0, 1'b0, 1'b0, 1'b1);
    check("R9 settled switch", 32'(proto_err), 0);

    finish_run();
  end

endmodule